// File: doc/BRIEF.md
# Coin-Operated Vending Controller

This block is the decision logic of a vending machine that sells one item at a fixed price of twenty cents. Each clock cycle it can accept at most one coin event: a strobe marking the event valid and a two-bit code naming the coin. Three coins are recognised: the five-cent, ten-cent and twenty-five-cent pieces. The controller keeps the running credit of the current purchase in flip-flops. The credit can only be 0, 5, 10 or 15 cents, held as a count of five-cent units.

When a coin brings the credit to twenty cents or more, the controller raises a vend pulse in that same cycle. Alongside the pulse it reports the overpayment as change, counted in five-cent units. It then clears the credit so the next purchase starts from zero. Vend and change are combinational (Mealy) outputs. They depend on the present credit and the coin arriving in the cycle, so they last exactly as long as that coin event.

Top module: `vend_controller`

## Requirements
- R1: After reset the credit is zero: with no coin, vend and change are 0, and a first twenty-five-cent coin gives vend 1 with change 1.
- R2: The coin code is 2'b01 for five cents, 2'b10 for ten cents and 2'b11 for twenty-five cents. Change is reported in five-cent units.
- R3: vend is 1 in the same cycle as the valid coin that brings the credit to 20 cents or more.
- R4: When vend is 1, change equals the credit plus the coin value minus 20 cents, in five-cent units. This gives a value from 0 to 4 (15 cents plus a twenty-five-cent coin gives 4).
- R5: The cycle after a vend, the credit is zero.
- R6: A valid coin that leaves the total below 20 cents adds its value to the credit, and vend and change stay 0.
- R7: A coin event has no effect when coin_valid is 0 or the code is 2'b00. In that cycle vend and change are 0 and the credit is unchanged.
- R8: change is nonzero only while vend is 1, and neither output is held beyond the cycle of the completing coin.
- R9: A synchronous reset clears the credit at the clock edge. During a cycle with rst high, vend and change are 0 even if a coin is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| coin_valid | input | 1 | Marks coin_code as a real coin event this cycle |
| coin_code | input | 2 | Coin type: 00 none, 01 five, 10 ten, 11 twenty-five cents |
| vend | output | 1 | Dispense pulse, same cycle as the completing coin |
| change | output | 3 | Overpayment in five-cent units, valid while vend is 1 |

## Verification
The assertions check four things on every cycle. Change never appears without vend and never exceeds four units. An invalid strobe never produces a payout. The credit register is zero after a vend or a reset, and it grows by exactly the coin's value on a non-completing coin. Only the bench's scenarios can show that the coin codes map to the right values and that each overshoot gives the right change amount. They also show that ignored events leave the credit untouched and that a reset in mid-purchase discards the partial credit; both are seen through the payout of the coins that follow.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int UNIT_CENTS     = 5;
    localparam int PRICE_UNITS    = 4;
    localparam int MAX_COIN_UNITS = 5;
    localparam int CREDIT_W       = $clog2(PRICE_UNITS);
    localparam int SUM_W          = $clog2(PRICE_UNITS + MAX_COIN_UNITS);
    localparam int CHANGE_W       = $clog2(MAX_COIN_UNITS + 1);

    typedef enum logic [1:0] {
        COIN_NONE    = 2'b00,
        COIN_FIVE    = 2'b01,
        COIN_TEN     = 2'b10,
        COIN_QUARTER = 2'b11
    } coin_e;

    typedef struct packed {
        logic                vend;
        logic [CHANGE_W-1:0] change;
    } payout_t;

    function automatic logic [SUM_W-1:0] coin_units(input coin_e c);
        case (c)
            COIN_FIVE:    coin_units = SUM_W'(1);
            COIN_TEN:     coin_units = SUM_W'(2);
            COIN_QUARTER: coin_units = SUM_W'(MAX_COIN_UNITS);
            default:      coin_units = '0;
        endcase
    endfunction

endpackage

// File: rtl/vend_coin_value.sv
module vend_coin_value
    import vend_pkg::*;
(
    input  logic             coin_valid,
    input  coin_e            coin_code,
    output logic [SUM_W-1:0] units
);
    always_comb begin
        units = coin_valid ? coin_units(coin_code) : '0;
    end
endmodule

// File: rtl/vend_settle.sv
module vend_settle
    import vend_pkg::*;
(
    input  logic                rst,
    input  logic [CREDIT_W-1:0] credit,
    input  logic [SUM_W-1:0]    units,
    output payout_t             pay,
    output logic [CREDIT_W-1:0] next_credit
);
    logic [SUM_W-1:0] total;
    logic             reached;

    always_comb begin
        total   = SUM_W'(credit) + units;
        reached = (total >= SUM_W'(PRICE_UNITS));
        pay     = '0;
        if (!rst && reached) begin
            pay.vend   = 1'b1;
            pay.change = CHANGE_W'(total - SUM_W'(PRICE_UNITS));
        end
        next_credit = reached ? '0 : total[CREDIT_W-1:0];
    end
endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg
    import vend_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [CREDIT_W-1:0] next_credit,
    output logic [CREDIT_W-1:0] credit
);
    always_ff @(posedge clk) begin
        if (rst) credit <= '0;
        else     credit <= next_credit;
    end

    // R9
    reset_clears_credit_chk: assert property (@(posedge clk) rst |=> credit == '0);
endmodule

// File: rtl/vend_controller.sv
module vend_controller
    import vend_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                coin_valid,
    input  logic [1:0]          coin_code,
    output logic                vend,
    output logic [CHANGE_W-1:0] change
);
    logic [SUM_W-1:0]    units;
    logic [CREDIT_W-1:0] credit;
    logic [CREDIT_W-1:0] next_credit;
    payout_t             pay;

    vend_coin_value u_value (
        .coin_valid (coin_valid),
        .coin_code  (coin_e'(coin_code)),
        .units      (units)
    );

    vend_settle u_settle (
        .rst         (rst),
        .credit      (credit),
        .units       (units),
        .pay         (pay),
        .next_credit (next_credit)
    );

    vend_credit_reg u_credit (
        .clk         (clk),
        .rst         (rst),
        .next_credit (next_credit),
        .credit      (credit)
    );

    assign vend   = pay.vend;
    assign change = pay.change;

    // R5
    vend_clears_credit_chk: assert property (@(posedge clk) disable iff (rst)
        vend |=> credit == '0);

    // R6
    credit_accumulates_chk: assert property (@(posedge clk) disable iff (rst)
        (units != '0 && !vend) |=> int'(credit) == int'($past(credit)) + int'($past(units)));

    // R7
    invalid_no_payout_chk: assert property (@(posedge clk) disable iff (rst)
        !coin_valid |-> (!vend && change == '0));

    // R8
    change_needs_vend_chk: assert property (@(posedge clk) disable iff (rst)
        change != '0 |-> vend);

    // R4
    change_bound_chk: assert property (@(posedge clk) disable iff (rst)
        vend |-> change <= CHANGE_W'(MAX_COIN_UNITS - 1));
endmodule

// File: tb/vend_controller_test.sv
`timescale 1ns/1ps
module vend_controller_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coin_valid = 1'b0;
    logic [1:0] coin_code = 2'b00;
    logic       vend;
    logic [2:0] change;

    int checks = 0;
    int fails  = 0;
    int cred   = 0;
    bit done   = 1'b0;

    bit         exp_vend_q[$];
    logic [2:0] exp_chg_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    vend_controller uut (
        .clk        (clk),
        .rst        (rst),
        .coin_valid (coin_valid),
        .coin_code  (coin_code),
        .vend       (vend),
        .change     (change)
    );

    task automatic step(input bit r, input bit v, input logic [1:0] c, input string tag);
        int val;
        int tot;
        bit ev;
        logic [2:0] ec;
        @(negedge clk);
        rst = r; coin_valid = v; coin_code = c;
        ev = 1'b0; ec = 3'd0;
        if (r) begin
            cred = 0;
        end else if (v && c != 2'b00) begin
            val = (c == 2'b01) ? 5 : (c == 2'b10) ? 10 : 25;
            tot = cred + val;
            if (tot >= 20) begin
                ev = 1'b1; ec = 3'((tot - 20) / 5); cred = 0;
            end else begin
                cred = tot;
            end
        end
        exp_vend_q.push_back(ev);
        exp_chg_q.push_back(ec);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            if (tag_q.size() > 0) begin
                bit ev;
                logic [2:0] ec;
                string t;
                ev = exp_vend_q.pop_front();
                ec = exp_chg_q.pop_front();
                t  = tag_q.pop_front();
                checks++;
                if (vend !== ev || change !== ec) begin
                    fails++;
                    $display("FAIL %s: vend=%0b change=%0d expected vend=%0b change=%0d",
                             t, vend, change, ev, ec);
                end
            end
        end
    end

    initial begin : watchdog
        #2000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : driver
        step(1, 0, 2'b00, "R1 reset idle");
        step(1, 1, 2'b11, "R9 coin during reset");
        step(0, 0, 2'b00, "R1 idle after reset");
        step(0, 1, 2'b11, "R1 R2 R3 R4 quarter from zero");
        step(0, 0, 2'b00, "R8 no hold after vend");
        step(0, 1, 2'b01, "R6 R2 five");
        step(0, 1, 2'b01, "R6 ten total");
        step(0, 1, 2'b01, "R6 fifteen total");
        step(0, 1, 2'b01, "R3 exact with five");
        step(0, 1, 2'b10, "R5 credit cleared");
        step(0, 1, 2'b10, "R3 R2 dime completes");
        step(0, 1, 2'b01, "R6 five");
        step(0, 1, 2'b10, "R6 fifteen via dime");
        step(0, 1, 2'b11, "R4 max change");
        step(0, 1, 2'b01, "R6 five");
        step(0, 1, 2'b10, "R6 fifteen");
        step(0, 1, 2'b10, "R4 change one");
        step(0, 1, 2'b10, "R6 ten");
        step(0, 0, 2'b11, "R7 strobe low");
        step(0, 1, 2'b00, "R7 code none");
        step(0, 0, 2'b10, "R7 strobe low dime");
        step(0, 1, 2'b10, "R7 credit kept");
        step(0, 1, 2'b10, "R6 ten");
        step(0, 1, 2'b01, "R6 fifteen");
        step(1, 1, 2'b11, "R9 reset mid purchase");
        step(0, 1, 2'b10, "R9 credit discarded");
        step(0, 1, 2'b10, "R9 exact after reset");
        step(0, 1, 2'b11, "R5 quarter");
        step(0, 1, 2'b11, "R5 R8 back to back quarter");
        step(0, 1, 2'b10, "R6 ten");
        step(0, 1, 2'b11, "R4 change three");
        step(0, 0, 2'b00, "R8 idle");
        @(negedge clk);
        #5;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule